// File: doc/BRIEF.md
# Half-Precision Reciprocal Square Root Unit

This unit accepts one IEEE 754 binary16 operand per clock and returns an estimate of 1/sqrt(x), also in binary16, two clocks later. It is fully pipelined, so a new operand can enter on every cycle. Every operand class has a fixed treatment. Finite positive values, normal or subnormal, go through a computed path. Zeros, infinities, negative numbers and NaNs map straight to fixed codes.

On the computed path, a subnormal operand is first normalised with a leading-zero count. The unbiased exponent is then split into an even part and a parity bit. The even part is halved and negated to form the result exponent. The parity bit and the leading fraction bits select a seed from a table that is computed at elaboration. One Newton–Raphson step refines the seed, and the result is rounded to nearest-even. The result for an exact even power of two is built directly, so it is exact.

Top module: `hrsqrt_unit`

## Requirements
- R1: Operand 0x0000 gives 0x7C00 (+infinity). Operand 0x8000 gives 0xFC00 (−infinity).
- R2: Operand 0x7C00 (+infinity) gives 0x0000.
- R3: Any operand with sign bit 15 set that is neither a zero nor a NaN gives the default quiet NaN 0xFE00. This includes 0xFC00 (−infinity) and negative subnormals.
- R4: A NaN operand (exponent field bits 14:10 all ones, fraction bits 9:0 nonzero) comes back unchanged except that bit 9, the quiet bit, is forced to 1. The sign and the rest of the payload are kept.
- R5: For a finite positive normal operand, the result is a positive normal number, and its relative error against the exact 1/sqrt(x) is below 2^-11 + 2^-14.
- R6: A positive subnormal operand (exponent field zero, fraction nonzero) gives a positive normal result (exponent field from 1 to 30), within the same error bound. No operand ever produces an overflow to infinity.
- R7: A positive operand equal to 2^(-2n) for an integer n, normal or subnormal, gives exactly 2^n: fraction zero and exponent field 15+n.
- R8: If in_valid is high at a rising edge, out_valid is high after the second rising edge that follows. Back-to-back operands give back-to-back results.
- R9: Holding rst_n low at a rising edge clears out_valid and out_data to zero. Any operand already in flight is dropped.
- R10: If in_valid is low at a rising edge, out_valid is low after the second rising edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe; in_data is sampled when high |
| in_data | input | 16 | Binary16 operand |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_data | output | 16 | Binary16 result; holds its last value while out_valid is low |

## Verification
The embedded properties assume that in_valid and in_data carry known values at every rising edge while rst_n is high. They also assume that reset is held for at least one full edge, so the two pipeline stages start empty. The latency properties look back only across edges where reset was high, and the class properties only fire when in_valid marks the operand as meaningful. The bench drives every input on the falling edge with defined values from time zero and holds reset low for three edges before any operand. It mixes single operands separated by idle cycles with an unbroken stream of all 65536 encodings, so each property sees both isolated and back-to-back traffic.

// File: rtl/hrsqrt_pkg.sv
// Package: shared constants, the stage-1 record and the seed generator for
// the binary16 reciprocal square root unit.
// Assumes: binary16 layout (1 sign, 5 exponent, 10 fraction bits).
package hrsqrt_pkg;

    localparam int HW   = 16;
    localparam int EW   = 5;
    localparam int MW   = 10;
    localparam int LZ_W = $clog2(MW + 1);

    localparam logic [HW-1:0] POS_INF   = 16'h7C00;
    localparam logic [HW-1:0] NEG_INF   = 16'hFC00;
    localparam logic [HW-1:0] POS_ZERO  = 16'h0000;
    localparam logic [HW-1:0] QNAN_DFLT = 16'hFE00;

    // Decoded operand as held between the two pipeline stages.
    typedef struct packed {
        logic          is_spec;   // result fixed, no arithmetic needed
        logic [HW-1:0] spec_val;  // the fixed result
        logic          is_pow;    // exact even power of two
        logic [EW-1:0] res_exp;   // biased exponent before rounding carry
        logic          parity;    // odd unbiased exponent
        logic [MW-1:0] frac;      // normalised fraction bits
    } dec_t;

    // Seed for table entry ent = {parity, top iw fraction bits}: the value
    // floor(2^sw / sqrt(x_mid)), x_mid the midpoint of the entry's interval,
    // doubled when parity is odd. Integer-only so it runs at elaboration.
    function automatic logic [31:0] seed_calc(input int iw, input int sw, input int ent);
        logic [63:0] num;
        logic [63:0] quo;
        logic [63:0] root;
        logic [63:0] cand;
        num = (64'd1 << (iw + 1)) + 64'(2 * (ent & ((1 << iw) - 1)) + 1);
        if (((ent >> iw) & 1) != 0) begin
            num = num << 1;
        end
        quo  = (64'd1 << (iw + 1 + 2 * sw)) / num;
        root = '0;
        for (int b = 31; b >= 0; b--) begin
            cand = root | (64'd1 << b);
            if (cand * cand <= quo) begin
                root = cand;
            end
        end
        return root[31:0];
    endfunction

endpackage

// File: rtl/hrsqrt_decode.sv
// Module: operand decoder. Sorts the operand into a fixed-result class or the
// computed path. For the computed path it normalises subnormals with a
// leading-zero count, splits off exponent parity and forms the halved,
// negated result exponent.
// Assumes: purely combinational; the caller registers the outputs.
module hrsqrt_decode
    import hrsqrt_pkg::*;
(
    input  logic [HW-1:0] op,
    output dec_t          dec
);

    logic          sgn;
    logic [EW-1:0] ef;
    logic [MW-1:0] mf;
    logic          is_sub;
    logic [LZ_W-1:0] lz;
    logic          hit;
    logic signed [6:0] e_unb;
    logic signed [6:0] k_even;
    logic signed [6:0] half_k;
    logic signed [6:0] r_exp;

    assign sgn    = op[HW-1];
    assign ef     = op[HW-2 -: EW];
    assign mf     = op[MW-1:0];
    assign is_sub = (ef == '0);

    // Leading-zero count of the fraction, used only for subnormals.
    always_comb begin
        lz  = '0;
        hit = 1'b0;
        for (int i = MW - 1; i >= 0; i--) begin
            if (!hit && mf[i]) begin
                lz  = LZ_W'(MW - 1 - i);
                hit = 1'b1;
            end
        end
    end

    // Unbiased exponent, its parity and the biased result exponent.
    always_comb begin
        e_unb  = is_sub ? (-7'sd15 - $signed({3'b000, lz}))
                        : ($signed({2'b00, ef}) - 7'sd15);
        k_even = e_unb - $signed({6'b000000, e_unb[0]});
        half_k = k_even >>> 1;
        r_exp  = 7'sd14 - half_k;
    end

    // Class selection and record assembly.
    always_comb begin
        dec          = '0;
        dec.parity   = e_unb[0];
        dec.res_exp  = r_exp[EW-1:0];
        dec.frac     = is_sub ? (mf << (lz + 1'b1)) : mf;
        dec.is_spec  = 1'b1;
        if (ef == '1 && mf != '0) begin
            dec.spec_val = {sgn, {EW{1'b1}}, 1'b1, mf[MW-2:0]};
        end else if (ef == '0 && mf == '0) begin
            dec.spec_val = sgn ? NEG_INF : POS_INF;
        end else if (sgn) begin
            dec.spec_val = QNAN_DFLT;
        end else if (ef == '1) begin
            dec.spec_val = POS_ZERO;
        end else begin
            dec.is_spec  = 1'b0;
        end
        dec.is_pow = !dec.is_spec && (dec.frac == '0) && !dec.parity;
    end

endmodule

// File: rtl/hrsqrt_seed_rom.sv
// Module: seed table. One entry per {exponent parity, leading fraction bits};
// each entry is computed at elaboration by the package generator.
// Assumes: IDX_W <= 10 so the index fits inside the fraction.
module hrsqrt_seed_rom #(
    parameter int IDX_W  = 7,
    parameter int SEED_W = 16
) (
    input  logic [IDX_W:0]    idx,
    output logic [SEED_W-1:0] seed
);

    localparam int ENTRIES = 2 ** (IDX_W + 1);

    logic [SEED_W-1:0] rom_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        localparam logic [SEED_W-1:0] ENTRY_VAL =
            SEED_W'(hrsqrt_pkg::seed_calc(IDX_W, SEED_W, g));
        assign rom_q[g] = ENTRY_VAL;
    end

    assign seed = rom_q[idx];

endmodule

// File: rtl/hrsqrt_refine.sv
// Module: one Newton-Raphson step on the seed, then round to nearest-even and
// pack the binary16 result. Fixed point: a is the reduced operand in [1,4)
// with 10 fraction bits, the seed has SEED_W fraction bits, and the
// refinement carries REF_FRAC fraction bits. The product seed*(3 - a*seed^2)
// is the result significand in [1,2).
// Assumes: combinational; only valid for operands on the computed path.
module hrsqrt_refine
    import hrsqrt_pkg::*;
#(
    parameter int SEED_W   = 16,
    parameter int REF_FRAC = 20
) (
    input  logic              parity,
    input  logic [MW-1:0]     frac,
    input  logic [SEED_W-1:0] seed,
    input  logic [EW-1:0]     res_exp,
    input  logic              is_pow,
    output logic [HW-1:0]     result,
    output logic              norm_ok
);

    localparam int A_W     = MW + 2;
    localparam int A_FRAC  = MW;
    localparam int SQ_W    = 2 * SEED_W;
    localparam int TF_W    = A_W + SQ_W;
    localparam int T_SHIFT = A_FRAC + SQ_W - REF_FRAC;
    localparam int H_W     = REF_FRAC + 2;
    localparam int P_W     = SEED_W + H_W;
    localparam int LEAD    = SEED_W + REF_FRAC;
    localparam int GRD     = LEAD - MW - 1;

    logic [A_W-1:0]  a_red;
    logic [SQ_W-1:0] ysq;
    logic [TF_W-1:0] t_full;
    logic [H_W-1:0]  t_fix;
    logic [H_W-1:0]  h_fix;
    logic [P_W-1:0]  prod;
    logic [MW-1:0]   mant;
    logic            guard;
    logic            sticky;
    logic            rnd_up;
    logic [MW:0]     rounded;
    logic [EW-1:0]   exp_out;

    // Reduced operand: 1.f for even parity, 2 x 1.f for odd parity.
    assign a_red = parity ? {1'b1, frac, 1'b0} : {2'b01, frac};

    // Newton-Raphson: t = a*y^2 (rounded up), h = 3 - t, 2*y1 = y*h.
    always_comb begin
        ysq    = SQ_W'(seed) * SQ_W'(seed);
        t_full = TF_W'(a_red) * TF_W'(ysq);
        t_fix  = t_full[T_SHIFT +: H_W] + H_W'(|t_full[T_SHIFT-1:0]);
        h_fix  = (H_W'(3) << REF_FRAC) - t_fix;
        prod   = P_W'(seed) * P_W'(h_fix);
    end

    // Round to nearest-even and pack; exact powers bypass the arithmetic.
    always_comb begin
        mant    = prod[LEAD-1 -: MW];
        guard   = prod[GRD];
        sticky  = |prod[GRD-1:0];
        rnd_up  = guard && (sticky || mant[0]);
        rounded = {1'b0, mant} + (MW+1)'(rnd_up);
        exp_out = res_exp + EW'(rounded[MW]);
        norm_ok = (prod[P_W-1:LEAD] == 2'b01);
        if (is_pow) begin
            result = {1'b0, res_exp + EW'(1), {MW{1'b0}}};
        end else begin
            result = {1'b0, exp_out, rounded[MW-1:0]};
        end
    end

endmodule

// File: rtl/hrsqrt_unit.sv
// Module: top of the binary16 reciprocal square root pipeline.
// Stage 1 decodes the operand and reads the seed table; stage 2 refines,
// rounds and registers the result. Latency two cycles, one operand per cycle.
// Assumes: synchronous active-low reset held for at least one rising edge.
module hrsqrt_unit
    import hrsqrt_pkg::*;
#(
    parameter int SEED_IDX_W = 7,
    parameter int SEED_W     = 16,
    parameter int REF_FRAC   = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [15:0]   in_data,
    output logic          out_valid,
    output logic [15:0]   out_data
);

    dec_t              dec;
    dec_t              s1_rec;
    logic              s1_valid;
    logic [SEED_IDX_W:0] seed_idx;
    logic [SEED_W-1:0] seed_c;
    logic [SEED_W-1:0] s1_seed;
    logic [HW-1:0]     rf_result;
    logic              rf_norm_ok;

    hrsqrt_decode u_decode (
        .op  (in_data),
        .dec (dec)
    );

    assign seed_idx = {dec.parity, dec.frac[MW-1 -: SEED_IDX_W]};

    hrsqrt_seed_rom #(
        .IDX_W  (SEED_IDX_W),
        .SEED_W (SEED_W)
    ) u_seed_rom (
        .idx  (seed_idx),
        .seed (seed_c)
    );

    // Stage 1 register: decoded record and seed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_rec   <= '0;
            s1_seed  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_rec  <= dec;
                s1_seed <= seed_c;
            end
        end
    end

    hrsqrt_refine #(
        .SEED_W   (SEED_W),
        .REF_FRAC (REF_FRAC)
    ) u_refine (
        .parity  (s1_rec.parity),
        .frac    (s1_rec.frac),
        .seed    (s1_seed),
        .res_exp (s1_rec.res_exp),
        .is_pow  (s1_rec.is_pow),
        .result  (rf_result),
        .norm_ok (rf_norm_ok)
    );

    // Stage 2 register: select fixed or computed result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= s1_rec.is_spec ? s1_rec.spec_val : rf_result;
            end
        end
    end

    // R8
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R10
    idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == 16'h0000));

    // R3
    neg_to_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[15] && in_data[14:0] != 15'h0
         && !(in_data[14:10] == 5'h1F && in_data[9:0] != 10'h0))
        |=> ##1 (out_data == 16'h FE00));

    // R4
    nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[14:10] == 5'h1F && in_data[9:0] != 10'h0)
        |=> ##1 (out_data == ($past(in_data, 2) | 16'h0200)));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_data[15] && in_data[14:10] != 5'h1F && in_data[14:0] != 15'h0)
        |=> ##1 (out_data[14:10] != 5'h1F && out_data[14:10] != 5'h00 && !out_data[15]));

    // R5
    sig_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_rec.is_spec && !s1_rec.is_pow) |-> rf_norm_ok);

endmodule

// File: tb/hrsqrt_unit_tb.sv
`timescale 1ns/1ps
// Bench: directed vector table with idle gaps, a full sweep of all encodings,
// and reset checks. Results are compared against a real-valued model.
module hrsqrt_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_data;
    logic        out_valid;
    logic [15:0] out_data;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic        drv_exact;
    logic [15:0] drv_exp;
    logic        hv0, hv1, hx0, hx1;
    logic [15:0] hd0, hd1, he0, he1;

    always #4 clk = ~clk;

    hrsqrt_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // {operand, exact expected result}
    localparam int NV = 18;
    localparam logic [31:0] VEC [NV] = '{
        32'h0000_7C00,  // R1 +0
        32'h8000_FC00,  // R1 -0
        32'h7C00_0000,  // R2 +inf
        32'hFC00_FE00,  // R3 -inf
        32'hBC00_FE00,  // R3 -1.0
        32'h8001_FE00,  // R3 negative subnormal
        32'h83FF_FE00,  // R3
        32'h7C01_7E01,  // R4 signalling NaN quieted
        32'h7E00_7E00,  // R4 quiet NaN
        32'hFD23_FF23,  // R4 negative NaN keeps sign
        32'h3C00_3C00,  // R7 1.0
        32'h4400_3800,  // R7 4 -> 0.5
        32'h3400_4000,  // R7 0.25 -> 2
        32'h7400_2000,  // R7 2^14 -> 2^-7
        32'h0400_5800,  // R7 2^-14 -> 2^7
        32'h0001_6C00,  // R7 2^-24 -> 2^12
        32'h0004_6800,  // R7 2^-22 -> 2^11
        32'h0100_5C00   // R7 2^-16 -> 2^8
    };

    function automatic real h2r(input logic [15:0] h);
        real mag;
        int  e;
        e = int'(h[14:10]);
        if (e == 0) mag = real'(h[9:0]) * $pow(2.0, -24);
        else        mag = real'(1024 + int'(h[9:0])) * $pow(2.0, e - 25);
        return h[15] ? -mag : mag;
    endfunction

    task automatic tally(input bit ok, input string req, input logic [15:0] x,
                         input logic [15:0] got, input logic [15:0] want);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s in=%h got=%h expected=%h", req, x, got, want);
        end
    endtask

    task automatic check_result(input logic [15:0] x, input logic [15:0] y,
                                input logic ex, input logic [15:0] ev);
        string       req;
        logic [15:0] want;
        bit          known;
        bit          ispow;
        int          eu;
        logic [4:0]  e;
        logic [9:0]  m;
        real         rf;
        real         err;
        e = x[14:10];
        m = x[9:0];
        known = 1;
        want  = '0;
        ispow = 0;
        eu    = 0;
        if (e == 5'h1F && m != 0) begin
            req = "R4"; want = x | 16'h0200;
        end else if (x[14:0] == 0) begin
            req = "R1"; want = x[15] ? 16'hFC00 : 16'h7C00;
        end else if (x[15]) begin
            req = "R3"; want = 16'hFE00;
        end else if (e == 5'h1F) begin
            req = "R2"; want = 16'h0000;
        end else begin
            if (e != 0 && m == 0) begin
                ispow = 1; eu = int'(e) - 15;
            end else if (e == 0 && $countones(m) == 1) begin
                ispow = 1;
                for (int b = 0; b < 10; b++) if (m[b]) eu = b - 24;
            end
            if (ispow && (eu % 2 == 0)) begin
                req = "R7"; want = {1'b0, 5'(15 - eu / 2), 10'd0};
            end else begin
                known = 0;
                req = (e == 0) ? "R6" : "R5";
            end
        end
        if (known) begin
            tally(y == want, req, x, y, want);
        end else begin
            nchk++;
            rf  = 1.0 / $sqrt(h2r(x));
            err = (h2r(y) - rf) / rf;
            if (err < 0.0) err = -err;
            if (y[15] || y[14:10] == 5'h00 || y[14:10] == 5'h1F
                || err >= (1.0 / 2048.0 + 1.0 / 16384.0)) begin
                nerr++;
                $display("FAIL %s in=%h got=%h (%e) expected=%e rel_err=%e",
                         req, x, y, h2r(y), rf, err);
            end
        end
        if (ex) tally(y == ev, req, x, y, ev);
    endtask

    task automatic finish_run;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // Expected-stream delay line, two edges deep.
    always @(posedge clk) begin
        if (!rst_n) begin
            hv0 <= 0; hv1 <= 0; hx0 <= 0; hx1 <= 0;
            hd0 <= '0; hd1 <= '0; he0 <= '0; he1 <= '0;
        end else begin
            hv1 <= hv0; hd1 <= hd0; hx1 <= hx0; he1 <= he0;
            hv0 <= in_valid; hd0 <= in_data; hx0 <= drv_exact && in_valid; he0 <= drv_exp;
        end
    end

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            if (hv1) tally(out_valid == 1'b1, "R8", hd1, {15'h0, out_valid}, 16'h0001);
            else     tally(out_valid == 1'b0, "R10", hd1, {15'h0, out_valid}, 16'h0000);
            if (hv1 && out_valid) check_result(hd1, out_data, hx1, he1);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL R8 watchdog got=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 0; in_valid = 0; in_data = '0; drv_exact = 0; drv_exp = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        tally(out_valid == 0 && out_data == 16'h0000, "R9", 16'h0000, out_data, 16'h0000);
        rst_n = 1;
        // Directed table with idle cycles between operands (R10 gaps).
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid = 1; in_data = VEC[i][31:16]; drv_exact = 1; drv_exp = VEC[i][15:0];
            @(negedge clk);
            in_valid = 0; drv_exact = 0;
        end
        // Back-to-back sweep of every encoding (R5, R6, R7, R8).
        for (int i = 0; i < 65536; i++) begin
            @(negedge clk);
            in_valid = 1; in_data = 16'(i);
        end
        @(negedge clk);
        in_valid = 0;
        repeat (4) @(negedge clk);
        // R9: operand in flight is dropped by reset.
        in_valid = 1; in_data = 16'h3C00;
        @(negedge clk);
        in_valid = 0; rst_n = 0;
        @(negedge clk);
        tally(out_valid == 0 && out_data == 16'h0000, "R9", 16'h3C00, out_data, 16'h0000);
        rst_n = 1;
        repeat (4) @(negedge clk);
        tally(out_valid == 0, "R9", 16'h3C00, {15'h0, out_valid}, 16'h0000);
        done = 1;
        finish_run();
    end

endmodule